// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder Model

This block acts as the memory side of an asynchronous-strobe DRAM interface, rebuilt as synchronous logic so that it can sit beside a memory controller under test. The active-low row strobe, column strobe, write enable and output enable are sampled on every clock, together with the multiplexed address. The block works out what kind of cycle is running from the order in which the strobes fall and rise. It can recognise a read, an early write, a late write, a refresh of one row only, and a refresh in which the column strobe leads. It holds a small word-wide array, drives or releases a 4-bit data bus, and keeps an internal refresh row counter.

A coverage bitmap records every row that has been activated since the last clear. A bench can use it to confirm that a controller's refresh sweep reached all rows. The array depth is reduced from a real part, while the strobe ordering rules are kept.

Top module: `dram_strobe_model`

## Requirements
- R1: After reset the bus is released (`dq_oe_o` low), `ref_row_o` is 0, `cov_o` is all zero and `kind_o` is 0 (none).
- R2: A row falling edge while the column strobe is high latches `addr_i` as the row. A column falling edge latches `addr_i` as the column. With write enable high, the bus is driven one clock after the later of the column and output-enable falls. `dq_o` then shows the stored word, and `kind_o` is 1 (read).
- R3: If write enable is low when the column strobe falls, `dq_i` at that edge is stored, the bus is never driven and `kind_o` is 2 (early write).
- R4: If write enable falls while the column strobe is low during a read access, `dq_i` at that edge is stored at the latched column, `kind_o` becomes 3 (late write) and the bus is not driven from then on.
- R5: The bus is released one clock after output enable is high, or the column strobe is high, or both strobes are high.
- R6: If the column strobe is low when the row strobe falls, the cycle is a refresh with `kind_o` 5. The address inputs are ignored, the array is not changed and the bus stays released. `ref_row_o` advances by one at the row strobe rise and wraps from the last row to 0.
- R7: If the row strobe rises without any column fall since it fell, `kind_o` is 4 (row-only refresh).
- R8: Every row strobe fall sets the coverage bit of the activated row, which is either the latched row or the counter row. `cov_clr_i` clears all bits, and `cov_all_o` is high exactly when every bit is set.
- R9: Several column strobe pulses within one row strobe low period access different columns of the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W (3) | Multiplexed row/column address |
| dq_i | input | DATA_W (4) | Write data |
| dq_o | output | DATA_W (4) | Read data, zero while released |
| dq_oe_o | output | 1 | Bus drive enable |
| kind_o | output | 3 | Last classified cycle type |
| ref_row_o | output | ROW_W (3) | Internal refresh row counter |
| cov_clr_i | input | 1 | Clears the coverage bitmap |
| cov_o | output | ROWS (8) | Rows activated since the last clear |
| cov_all_o | output | 1 | All rows covered |

## Verification
The assertions check on every cycle that the bus is never driven unless, on the previous clock, the column strobe and output enable were low with write enable high. They also check that the bus is released while both strobes are high and during refresh and write classifications, and that the refresh counter moves only at the end of a column-first refresh, by exactly one. The bench scenarios are the only place where the data itself can be shown. These cover the stored values read back across the whole array, the late-write data, page-mode column changes, counter wrap and coverage completion after a full sweep.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;
  typedef enum logic [2:0] {
    K_NONE     = 3'd0,
    K_READ     = 3'd1,
    K_EARLY_WR = 3'd2,
    K_LATE_WR  = 3'd3,
    K_ROW_REF  = 3'd4,
    K_CBR      = 3'd5
  } cyc_kind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_CBR} phase_e;
  typedef enum logic [1:0] {ACC_NONE, ACC_READ, ACC_DONE} acc_e;
endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/dram_refresh_track.sv
module dram_refresh_track #(
  parameter int ROW_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cbr_end_i,
  input  logic                   act_i,
  input  logic [ROW_W-1:0]       act_row_i,
  input  logic                   cov_clr_i,
  output logic [ROW_W-1:0]       ref_row_o,
  output logic [(1<<ROW_W)-1:0]  cov_o,
  output logic                   cov_all_o
);
  localparam int ROWS = 1 << ROW_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_row_o <= '0;
    else if (cbr_end_i) ref_row_o <= ref_row_o + 1'b1;
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_cov
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cov_o[g] <= 1'b0;
      else if (cov_clr_i) cov_o[g] <= 1'b0;
      else if (act_i && act_row_i == ROW_W'(g)) cov_o[g] <= 1'b1;
    end
  end

  assign cov_all_o = &cov_o;
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_model_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ras_ni,
  input  logic                   cas_ni,
  input  logic                   we_ni,
  input  logic                   oe_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [ROW_W-1:0]       ref_row_i,
  output logic                   wr_en_o,
  output logic [ROW_W+COL_W-1:0] wr_addr_o,
  output logic [ROW_W+COL_W-1:0] rd_addr_o,
  output logic                   drive_o,
  output logic [2:0]             kind_o,
  output logic                   cbr_end_o,
  output logic                   act_o,
  output logic [ROW_W-1:0]       act_row_o
);
  logic ras_q, cas_q, we_q;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  phase_e    st_q, st_d;
  acc_e      acc_q, acc_d;
  cyc_kind_e kind_q, kind_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic seen_q, seen_d, drive_d;

  assign ras_fall = ras_q & ~ras_ni;
  assign ras_rise = ~ras_q & ras_ni;
  assign cas_fall = cas_q & ~cas_ni;
  assign cas_rise = ~cas_q & cas_ni;
  assign we_fall  = we_q & ~we_ni;

  always_comb begin
    st_d = st_q; acc_d = acc_q; kind_d = kind_q;
    row_d = row_q; col_d = col_q; seen_d = seen_q;
    wr_en_o = 1'b0; wr_addr_o = {row_q, col_q};
    cbr_end_o = 1'b0; act_o = 1'b0; act_row_o = addr_i[ROW_W-1:0];
    unique case (st_q)
      ST_IDLE: if (ras_fall) begin
        act_o = 1'b1;
        if (!cas_ni) begin
          st_d = ST_CBR; kind_d = K_CBR; act_row_o = ref_row_i;
        end else begin
          st_d = ST_ROW; row_d = addr_i[ROW_W-1:0]; seen_d = 1'b0; acc_d = ACC_NONE;
        end
      end
      ST_ROW: begin
        if (ras_rise) begin
          st_d = ST_IDLE; acc_d = ACC_NONE;
          if (!seen_q) kind_d = K_ROW_REF;
        end else if (cas_fall) begin
          col_d = addr_i[COL_W-1:0]; seen_d = 1'b1;
          if (!we_ni) begin
            wr_en_o = 1'b1; wr_addr_o = {row_q, addr_i[COL_W-1:0]};
            kind_d = K_EARLY_WR; acc_d = ACC_DONE;
          end else begin
            kind_d = K_READ; acc_d = ACC_READ;
          end
        end else if (cas_rise) begin
          acc_d = ACC_NONE;
        end else if (acc_q == ACC_READ && we_fall && !cas_ni) begin
          wr_en_o = 1'b1; kind_d = K_LATE_WR; acc_d = ACC_DONE;
        end
      end
      ST_CBR: if (ras_rise) begin
        st_d = ST_IDLE; cbr_end_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    drive_d = (st_d == ST_ROW) && (acc_d == ACC_READ) && !ras_ni && !cas_ni && !oe_ni && we_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1; cas_q <= 1'b1; we_q <= 1'b1;
      st_q <= ST_IDLE; acc_q <= ACC_NONE; kind_q <= K_NONE;
      row_q <= '0; col_q <= '0; seen_q <= 1'b0; drive_o <= 1'b0;
    end else begin
      ras_q <= ras_ni; cas_q <= cas_ni; we_q <= we_ni;
      st_q <= st_d; acc_q <= acc_d; kind_q <= kind_d;
      row_q <= row_d; col_q <= col_d; seen_q <= seen_d; drive_o <= drive_d;
    end
  end

  assign rd_addr_o = {row_q, col_q};
  assign kind_o    = kind_q;
endmodule

// File: rtl/dram_strobe_model.sv
module dram_strobe_model #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 4,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int ROWS   = 1 << ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [2:0]        kind_o,
  output logic [ROW_W-1:0]  ref_row_o,
  input  logic              cov_clr_i,
  output logic [ROWS-1:0]   cov_o,
  output logic              cov_all_o
);
  localparam int AW = ROW_W + COL_W;

  logic          wr_en, cbr_end, act;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [ROW_W-1:0] act_row;
  logic [DATA_W-1:0] rd_data;

  dram_strobe_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .ras_ni, .cas_ni, .we_ni, .oe_ni, .addr_i,
    .ref_row_i(ref_row_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .rd_addr_o(rd_addr), .drive_o(dq_oe_o), .kind_o(kind_o),
    .cbr_end_o(cbr_end), .act_o(act), .act_row_o(act_row)
  );

  dram_cell_array #(.AW(AW), .DW(DATA_W)) u_array (
    .clk_i, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(dq_i),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  dram_refresh_track #(.ROW_W(ROW_W)) u_ref (
    .clk_i, .rst_ni, .cbr_end_i(cbr_end), .act_i(act), .act_row_i(act_row),
    .cov_clr_i, .ref_row_o, .cov_o, .cov_all_o
  );

  assign dq_o = dq_oe_o ? rd_data : '0;
endmodule

// File: rtl/dram_strobe_model_chk.sv
module dram_strobe_model_chk #(
  parameter int ROW_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_ni,
  input logic             cas_ni,
  input logic             we_ni,
  input logic             oe_ni,
  input logic             dq_oe_o,
  input logic [2:0]       kind_o,
  input logic [ROW_W-1:0] ref_row_o
);
  logic in_cbr_q, ras_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cbr_q <= 1'b0; ras_prev_q <= 1'b1;
    end else begin
      ras_prev_q <= ras_ni;
      if (ras_prev_q && !ras_ni) in_cbr_q <= !cas_ni;
      else if (ras_ni) in_cbr_q <= 1'b0;
    end
  end

  // R2, R5
  p_drive_needs_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> $past(!cas_ni && !oe_ni && we_ni && !ras_ni));
  p_idle_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_ni && cas_ni) |=> !dq_oe_o);
  p_cbr_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == 3'd5) |-> !dq_oe_o);
  p_early_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == 3'd2) |-> !dq_oe_o);
  p_late_hiz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == 3'd3) |-> !dq_oe_o);
  p_cbr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cbr_q && ras_ni) |=> ref_row_o == ROW_W'($past(ref_row_o) + 1'b1));
  p_ctr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_cbr_q && ras_ni) |=> $stable(ref_row_o));
endmodule

bind dram_strobe_model dram_strobe_model_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i, .rst_ni, .ras_ni, .cas_ni, .we_ni, .oe_ni,
  .dq_oe_o, .kind_o, .ref_row_o
);

// File: tb/tb_dram_strobe_model.sv
module tb_dram_strobe_model;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 3, COL_W = 3, DATA_W = 4, ADDR_W = 3, ROWS = 8, COLS = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ras_ni = 1, cas_ni = 1, we_ni = 1, oe_ni = 1, cov_clr_i = 0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] dq_i = '0, dq_o;
  logic dq_oe_o, cov_all_o;
  logic [2:0] kind_o;
  logic [ROW_W-1:0] ref_row_o;
  logic [ROWS-1:0] cov_o;
  int checks = 0, errors = 0, exp_ref = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_strobe_model dut (.clk_i(clk), .rst_ni, .ras_ni, .cas_ni, .we_ni, .oe_ni,
    .addr_i, .dq_i, .dq_o, .dq_oe_o, .kind_o, .ref_row_o, .cov_clr_i, .cov_o, .cov_all_o);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [3:0] pat(input int r, input int c, input int s);
    return 4'((r * 3 + c * 5 + s) & 15);
  endfunction

  task automatic early_wr(input int r, input int c, input logic [3:0] d);
    addr_i = 3'(r); ras_ni = 0; tick();
    addr_i = 3'(c); we_ni = 0; dq_i = d; cas_ni = 0; tick();
    chk(kind_o == 3'd2 && !dq_oe_o, "R3 early write", kind_o, 2);
    cas_ni = 1; we_ni = 1; tick();
    ras_ni = 1; tick();
  endtask

  task automatic rd(input int r, input int c, input logic [3:0] e);
    addr_i = 3'(r); ras_ni = 0; tick();
    addr_i = 3'(c); cas_ni = 0; oe_ni = 0; tick();
    chk(dq_oe_o && dq_o == e && kind_o == 3'd1, "R2 read data", dq_o, e);
    oe_ni = 1; tick();
    chk(!dq_oe_o, "R5 release on oe high", dq_oe_o, 0);
    cas_ni = 1; ras_ni = 1; tick();
  endtask

  task automatic cbr();
    cas_ni = 0; tick();
    addr_i = 3'd5; ras_ni = 0; tick();
    chk(kind_o == 3'd5 && !dq_oe_o, "R6 cbr kind", kind_o, 5);
    ras_ni = 1; tick();
    exp_ref = (exp_ref + 1) % ROWS;
    chk(ref_row_o == 3'(exp_ref), "R6 counter step", ref_row_o, exp_ref);
    cas_ni = 1; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!dq_oe_o && ref_row_o == 0 && cov_o == 0 && kind_o == 0, "R1 reset state", kind_o, 0);
    rst_ni = 1; tick();

    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) early_wr(r, c, pat(r, c, 1));
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) rd(r, c, pat(r, c, 1));
    chk(cov_all_o, "R8 coverage after sweep", cov_o, 255);

    // R5: oe falls after cas, both strobes high releases
    addr_i = 3'd2; ras_ni = 0; tick();
    addr_i = 3'd6; cas_ni = 0; tick();
    chk(!dq_oe_o && kind_o == 3'd1, "R5 no drive before oe", dq_oe_o, 0);
    oe_ni = 0; tick();
    chk(dq_oe_o && dq_o == pat(2, 6, 1), "R2 oe-last read", dq_o, pat(2, 6, 1));
    cas_ni = 1; ras_ni = 1; tick();
    chk(!dq_oe_o, "R5 release both high", dq_oe_o, 0);
    oe_ni = 1;

    // R4 late write
    addr_i = 3'd4; ras_ni = 0; tick();
    addr_i = 3'd3; cas_ni = 0; tick();
    dq_i = 4'hA; we_ni = 0; tick();
    chk(kind_o == 3'd3 && !dq_oe_o, "R4 late write kind", kind_o, 3);
    oe_ni = 0; tick();
    chk(!dq_oe_o, "R4 no drive after late write", dq_oe_o, 0);
    oe_ni = 1; we_ni = 1; cas_ni = 1; ras_ni = 1; tick();
    rd(4, 3, 4'hA);

    // R9 page mode
    addr_i = 3'd1; ras_ni = 0; tick();
    for (int c = 0; c < COLS; c += 3) begin
      addr_i = 3'(c); cas_ni = 0; oe_ni = 0; tick();
      chk(dq_oe_o && dq_o == pat(1, c, 1), "R9 page read", dq_o, pat(1, c, 1));
      cas_ni = 1; oe_ni = 1; tick();
      chk(!dq_oe_o, "R5 release on cas high", dq_oe_o, 0);
    end
    addr_i = 3'd7; we_ni = 0; dq_i = 4'h3; cas_ni = 0; tick();
    cas_ni = 1; we_ni = 1; tick();
    ras_ni = 1; tick();
    rd(1, 7, 4'h3);

    // R6 cbr sweep with wrap and no array change; R8 coverage
    cov_clr_i = 1; tick(); cov_clr_i = 0;
    chk(cov_o == 0, "R8 clear", cov_o, 0);
    for (int i = 0; i < ROWS + 1; i++) cbr();
    chk(cov_all_o, "R8 cbr sweep covers all", cov_o, 255);
    rd(5, 5, pat(5, 5, 1));

    // R7 row-only refresh
    cov_clr_i = 1; tick(); cov_clr_i = 0;
    for (int r = 0; r < ROWS; r += 2) begin
      addr_i = 3'(r); ras_ni = 0; tick();
      ras_ni = 1; tick();
      chk(kind_o == 3'd4, "R7 row-only kind", kind_o, 4);
    end
    chk(cov_o == 8'h55 && !cov_all_o, "R8 partial coverage", cov_o, 8'h55);
    rd(6, 0, pat(6, 0, 1));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule